// File: doc/BRIEF.md
# I2C Register-File Target

This block is an I2C target (slave) that exposes sixteen 8-bit registers at one fixed 7-bit bus address. It oversamples the open-drain SCL and SDA lines with the system clock and finds START, repeated START and STOP. It then walks through address, write and read phases, and answers through two pull-low enables, one for SDA and one for SCL.

A bus controller writes one byte to set the internal register pointer, and then streams data bytes into consecutive registers. The pointer survives a repeated START and a STOP. This lets a controller set the pointer, issue a repeated START with the read bit, and stream registers back out. Each byte moves the pointer by one, and the pointer wraps at the end of the array.

Two more features are built in:
- The general-call address can be accepted, and its data bytes are then handed to the local side as broadcast commands.
- The target can hold SCL low after each acknowledge slot until the local side reports that it is ready.

Top module: `i2c_regfile_target`

## Requirements
- R1: After reset `sda_oe_o`, `scl_oe_o` and `gc_valid_o` are 0, and all registers read back as 0x00.
- R2: An address byte (7 address bits MSB first, then the R/W bit, where 1 means read) whose address equals `OWN_ADDR` is acknowledged: the target pulls SDA low during the 9th clock, for both values of R/W.
- R3: Any other address is not acknowledged. Until the next START the target leaves SDA released, and the bytes that follow neither get an ACK nor change any register.
- R4: In a write (R/W = 0), the first data byte loads the pointer from its low 4 bits. Each later byte is stored at the pointer and the pointer then increments. Every data byte is acknowledged.
- R5: In a read (R/W = 1), the target shifts out the register at the pointer, MSB first, and increments the pointer after each byte. It releases SDA during the acknowledge clock. SDA changes only while SCL is low, so it is stable across every SCL high phase.
- R6: The pointer wraps modulo 16 for both reads and writes.
- R7: When the controller NACKs a read byte, the target stops driving SDA and stays released for any further clocks until a STOP or START.
- R8: Address 0x00 with R/W = 0 is acknowledged only while `gc_en_i` is 1. Each data byte that follows is acknowledged and raised on `gc_valid_o` for one cycle, with the byte on `gc_data_o`, and no register changes. Address 0x00 with R/W = 1 is never acknowledged.
- R9: After each acknowledge clock of an accepted transfer, if `ready_i` is 0 the target holds SCL low (`scl_oe_o` = 1). It releases SCL within two cycles once `ready_i` is 1. It pulls SCL low only while SCL is already low.
- R10: A STOP releases both lines and returns the target to idle. The pointer is not reset by STOP or by a repeated START.
- R11: A START that arrives in the middle of a byte aborts it and restarts address reception.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Level of the SCL bus line |
| sda_i | input | 1 | Level of the SDA bus line |
| gc_en_i | input | 1 | Accept the general-call address |
| ready_i | input | 1 | Local side ready; when 0, SCL is stretched after the ACK slot |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| scl_oe_o | output | 1 | 1 pulls SCL low (clock stretch) |
| gc_valid_o | output | 1 | One-cycle pulse per general-call data byte |
| gc_data_o | output | 8 | Last general-call data byte |

## Verification
A wrong pointer shows up on the very next read byte: the target returns the wrong register, or the first byte after a repeated START or a STOP is off by one. This is why every start pointer is swept, including the ones that wrap. A bit counter that is out of step moves the ACK slot by one clock, so the ACK sampled on the 9th clock of the affected byte comes back high. A stale address match shows up as an ACK to a foreign address in the full address sweep, or as a changed register when it is read back afterwards.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WRITE,
    ST_READ,
    ST_IGNORE
  } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_line_mon.sv
module i2c_tgt_line_mon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic sda_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic scl_d, sda_d;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_sync <= '1;
          sda_sync <= '1;
        end else begin
          scl_sync <= scl_i;
          sda_sync <= sda_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_sync <= '1;
          sda_sync <= '1;
        end else begin
          scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
          sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  assign scl_o = scl_sync[SYNC_STAGES-1];
  assign sda_o = sda_sync[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_o;
      sda_d <= sda_o;
    end
  end

  assign scl_rise_o = scl_o & ~scl_d;
  assign scl_fall_o = ~scl_o & scl_d;
  // SDA edge while SCL stays high
  assign start_o = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o  = scl_o & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs #(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 8,
  localparam int PTR_W   = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PTR_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [PTR_W-1:0]  raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [NUM_REGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_REGS; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] OWN_ADDR = 7'h42,
  parameter int         PTR_W    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             sda_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             gc_en_i,
  input  logic             ready_i,
  input  logic [7:0]       rdata_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic             we_o,
  output logic [PTR_W-1:0] waddr_o,
  output logic [7:0]       wdata_o,
  output logic             sda_oe_o,
  output logic             scl_oe_o,
  output logic             gc_valid_o,
  output logic [7:0]       gc_data_o,
  output tgt_state_e       state_o
);
  tgt_state_e       state_q;
  logic [3:0]       bit_cnt_q;
  logic [7:0]       rx_q, tx_q;
  logic [PTR_W-1:0] ptr_q;
  logic             rw_q, gc_q, ptr_pend_q, m_nack_q;

  logic addr_hit, gc_hit, active;
  assign addr_hit = (rx_q[7:1] == OWN_ADDR);
  assign gc_hit   = gc_en_i && (rx_q == 8'h00);
  assign active   = (state_q == ST_ADDR) || (state_q == ST_WRITE) || (state_q == ST_READ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      bit_cnt_q  <= '0;
      rx_q       <= '0;
      tx_q       <= '0;
      ptr_q      <= '0;
      rw_q       <= 1'b0;
      gc_q       <= 1'b0;
      ptr_pend_q <= 1'b0;
      m_nack_q   <= 1'b0;
      sda_oe_o   <= 1'b0;
      scl_oe_o   <= 1'b0;
      we_o       <= 1'b0;
      waddr_o    <= '0;
      wdata_o    <= '0;
      gc_valid_o <= 1'b0;
      gc_data_o  <= '0;
    end else begin
      we_o       <= 1'b0;
      gc_valid_o <= 1'b0;
      if (scl_oe_o && ready_i) scl_oe_o <= 1'b0;
      if (start_i) begin
        state_q   <= ST_ADDR;
        bit_cnt_q <= '0;
        sda_oe_o  <= 1'b0;
        scl_oe_o  <= 1'b0;
      end else if (stop_i) begin
        state_q   <= ST_IDLE;
        bit_cnt_q <= '0;
        sda_oe_o  <= 1'b0;
        scl_oe_o  <= 1'b0;
      end else if (active && scl_rise_i) begin
        if (bit_cnt_q < 4'd8) rx_q <= {rx_q[6:0], sda_i};
        else if (state_q == ST_READ) m_nack_q <= sda_i;
        bit_cnt_q <= bit_cnt_q + 4'd1;
      end else if (active && scl_fall_i) begin
        if (bit_cnt_q == 4'd8) begin
          // entering the ACK slot
          unique case (state_q)
            ST_ADDR: begin
              if (addr_hit || gc_hit) begin
                sda_oe_o <= 1'b1;
                rw_q     <= rx_q[0];
                gc_q     <= gc_hit;
              end else begin
                state_q <= ST_IGNORE;
              end
            end
            ST_WRITE: begin
              sda_oe_o <= 1'b1;
              if (gc_q) begin
                gc_valid_o <= 1'b1;
                gc_data_o  <= rx_q;
              end else if (ptr_pend_q) begin
                ptr_q      <= rx_q[PTR_W-1:0];
                ptr_pend_q <= 1'b0;
              end else begin
                we_o    <= 1'b1;
                waddr_o <= ptr_q;
                wdata_o <= rx_q;
                ptr_q   <= ptr_q + 1'b1;
              end
            end
            default: begin
              sda_oe_o <= 1'b0;
              ptr_q    <= ptr_q + 1'b1;
            end
          endcase
        end else if (bit_cnt_q == 4'd9) begin
          // leaving the ACK slot
          bit_cnt_q <= '0;
          scl_oe_o  <= !ready_i;
          unique case (state_q)
            ST_ADDR: begin
              if (rw_q) begin
                state_q  <= ST_READ;
                tx_q     <= rdata_i;
                sda_oe_o <= ~rdata_i[7];
              end else begin
                state_q    <= ST_WRITE;
                ptr_pend_q <= 1'b1;
                sda_oe_o   <= 1'b0;
              end
            end
            ST_WRITE: sda_oe_o <= 1'b0;
            default: begin
              if (m_nack_q) begin
                state_q  <= ST_IGNORE;
                sda_oe_o <= 1'b0;
                scl_oe_o <= 1'b0;
              end else begin
                tx_q     <= rdata_i;
                sda_oe_o <= ~rdata_i[7];
              end
            end
          endcase
        end else if (state_q == ST_READ) begin
          tx_q     <= {tx_q[6:0], 1'b0};
          sda_oe_o <= ~tx_q[6];
        end
      end
    end
  end

  assign ptr_o   = ptr_q;
  assign state_o = state_q;
endmodule

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] OWN_ADDR    = 7'h42,
  parameter int         NUM_REGS    = 16,
  parameter int         SYNC_STAGES = 2,
  localparam int        PTR_W       = $clog2(NUM_REGS)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       gc_en_i,
  input  logic       ready_i,
  output logic       sda_oe_o,
  output logic       scl_oe_o,
  output logic       gc_valid_o,
  output logic [7:0] gc_data_o
);
  logic             scl_s, sda_s, scl_rise, scl_fall, start_s, stop_s;
  logic             we;
  logic [PTR_W-1:0] waddr, ptr;
  logic [7:0]       wdata, rdata;
  tgt_state_e       state_s;

  i2c_tgt_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_line (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .sda_o(sda_s), .start_o(start_s), .stop_o(stop_s)
  );

  i2c_tgt_regs #(.NUM_REGS(NUM_REGS), .DATA_W(8)) u_regs (
    .clk_i, .rst_ni, .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .raddr_i(ptr), .rdata_o(rdata)
  );

  i2c_tgt_ctrl #(.OWN_ADDR(OWN_ADDR), .PTR_W(PTR_W)) u_ctrl (
    .clk_i, .rst_ni, .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .sda_i(sda_s), .start_i(start_s), .stop_i(stop_s),
    .gc_en_i, .ready_i, .rdata_i(rdata), .ptr_o(ptr),
    .we_o(we), .waddr_o(waddr), .wdata_o(wdata),
    .sda_oe_o, .scl_oe_o, .gc_valid_o, .gc_data_o, .state_o(state_s)
  );
endmodule

// File: rtl/i2c_tgt_chk.sv
module i2c_tgt_chk
  import i2c_tgt_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sda_oe_o,
  input logic       scl_oe_o,
  input logic       gc_valid_o,
  input logic       ready_i,
  input logic       scl_s,
  input logic       start_s,
  input logic       stop_s,
  input tgt_state_e state_s
);
  AST_SDA_CHANGE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($changed(sda_oe_o) && !$past(start_s) && !$past(stop_s)) |-> !$past(scl_s)); // R5
  AST_STRETCH_ON_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_oe_o) |-> !$past(scl_s)); // R9
  AST_READY_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_oe_o && ready_i) |=> !scl_oe_o); // R9
  AST_GC_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gc_valid_o |=> !gc_valid_o); // R8
  AST_IGNORE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_s == ST_IGNORE) |-> (!sda_oe_o && !scl_oe_o)); // R3
  AST_STOP_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(stop_s) |-> (!sda_oe_o && !scl_oe_o && state_s == ST_IDLE)); // R10
endmodule

bind i2c_regfile_target i2c_tgt_chk u_chk (
  .clk_i, .rst_ni, .sda_oe_o, .scl_oe_o, .gc_valid_o, .ready_i,
  .scl_s, .start_s, .stop_s, .state_s
);

// File: tb/i2c_regfile_target_tb.sv
module i2c_regfile_target_tb_top;
  localparam int         CLK_PERIOD = 10;
  localparam logic [6:0] OWN        = 7'h42;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic gc_en = 1'b0, ready = 1'b1;
  logic sda_oe, scl_oe, gc_valid;
  logic [7:0] gc_data;
  logic scl_line, sda_line;

  assign scl_line = m_scl & ~scl_oe;
  assign sda_line = m_sda & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_regfile_target #(.OWN_ADDR(OWN)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .gc_en_i(gc_en), .ready_i(ready), .sda_oe_o(sda_oe), .scl_oe_o(scl_oe),
    .gc_valid_o(gc_valid), .gc_data_o(gc_data)
  );

  int n_chk = 0, n_fail = 0, gc_cnt = 0, glitch = 0;
  logic [7:0] gc_last = '0;
  logic [7:0] expv [16];
  bit done = 0;

  always @(posedge clk) if (gc_valid) begin gc_cnt <= gc_cnt + 1; gc_last <= gc_data; end

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp_v);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_high();
    while (!scl_line) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(4);
    m_scl = 1'b1; wait_high(); tick(4);
    m_sda = 1'b0; tick(4);
    m_scl = 1'b0; tick(4);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(4);
    m_scl = 1'b1; wait_high(); tick(4);
    m_sda = 1'b1; tick(8);
  endtask

  task automatic clock_bit(input logic b, output logic r);
    logic r1;
    m_sda = b; tick(4);
    m_scl = 1'b1; wait_high(); tick(1);
    r1 = sda_line; tick(3);
    r = sda_line;
    if (r1 !== r) glitch++;
    tick(4);
    m_scl = 1'b0; tick(4);
  endtask

  task automatic write_byte(input logic [7:0] b, output bit ack);
    logic r;
    for (int i = 7; i >= 0; i--) clock_bit(b[i], r);
    clock_bit(1'b1, r);
    ack = (r == 1'b0);
  endtask

  task automatic read_byte(input bit give_ack, output logic [7:0] b);
    logic r;
    for (int i = 7; i >= 0; i--) begin clock_bit(1'b1, r); b[i] = r; end
    clock_bit(give_ack ? 1'b0 : 1'b1, r);
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  initial begin
    bit ack;
    logic [7:0] d;
    tick(3);
    rst_n = 1'b1;
    tick(3);
    check(!sda_oe && !scl_oe && !gc_valid, "R1 outputs idle", {sda_oe, scl_oe, gc_valid}, 0);

    // R1: reset contents, read all 16 from pointer 0
    bus_start(); write_byte({OWN, 1'b0}, ack); write_byte(8'h00, ack);
    bus_start(); write_byte({OWN, 1'b1}, ack);
    check(ack, "R2 read addr ack", ack, 1);
    for (int i = 0; i < 16; i++) begin
      read_byte(i != 15, d);
      check(d == 8'h00, "R1 reset register", d, 0);
    end
    bus_stop();

    // R4: write all registers starting at pointer 0
    bus_start(); write_byte({OWN, 1'b0}, ack);
    check(ack, "R2 write addr ack", ack, 1);
    write_byte(8'h00, ack);
    check(ack, "R4 pointer byte ack", ack, 1);
    for (int i = 0; i < 16; i++) begin
      expv[i] = pat(i);
      write_byte(expv[i], ack);
      check(ack, "R4 data ack", ack, 1);
    end
    bus_stop();
    check(!sda_oe && !scl_oe, "R10 released after stop", {sda_oe, scl_oe}, 0);

    // R5/R6: every start pointer, three bytes each, repeated START
    for (int p = 0; p < 16; p++) begin
      bus_start(); write_byte({OWN, 1'b0}, ack); write_byte(8'(p), ack);
      bus_start(); write_byte({OWN, 1'b1}, ack);
      for (int k = 0; k < 3; k++) begin
        read_byte(k != 2, d);
        check(d == expv[(p + k) % 16], (p + k >= 16) ? "R6 wrap read" : "R5 read", d, expv[(p + k) % 16]);
      end
      bus_stop();
    end
    check(glitch == 0, "R5 SDA stable while SCL high", glitch, 0);

    // R10: pointer kept across STOP (15 + 3 wraps to 2)
    bus_start(); write_byte({OWN, 1'b1}, ack);
    read_byte(1'b0, d);
    check(d == expv[2], "R10 pointer kept across stop", d, expv[2]);
    bus_stop();

    // R6: write wrap from pointer 15
    bus_start(); write_byte({OWN, 1'b0}, ack); write_byte(8'h0F, ack);
    write_byte(8'hC3, ack); write_byte(8'h3C, ack);
    expv[15] = 8'hC3; expv[0] = 8'h3C;
    bus_start(); write_byte({OWN, 1'b0}, ack); write_byte(8'h0F, ack);
    bus_start(); write_byte({OWN, 1'b1}, ack);
    read_byte(1'b1, d); check(d == 8'hC3, "R6 write at 15", d, 8'hC3);
    read_byte(1'b0, d); check(d == 8'h3C, "R6 write wrapped to 0", d, 8'h3C);
    bus_stop();

    // R3: sweep every foreign address (general call disabled)
    gc_en = 1'b0;
    for (int a = 0; a < 128; a++) begin
      if (a == int'(OWN)) continue;
      bus_start(); write_byte({7'(a), 1'b0}, ack);
      check(!ack, (a == 0) ? "R8 gc disabled nack" : "R3 foreign addr nack", ack, 0);
      write_byte(8'h00, ack);
      check(!ack, "R3 ignored pointer byte", ack, 0);
      write_byte(8'hEE, ack);
      check(!ack, "R3 ignored data byte", ack, 0);
      bus_stop();
    end
    bus_start(); write_byte({OWN, 1'b0}, ack); write_byte(8'h00, ack);
    bus_start(); write_byte({OWN, 1'b1}, ack);
    read_byte(1'b0, d);
    check(d == expv[0], "R3 register untouched", d, expv[0]);
    bus_stop();

    // R8: general call enabled
    gc_en = 1'b1;
    bus_start(); write_byte(8'h00, ack);
    check(ack, "R8 gc addr ack", ack, 1);
    write_byte(8'h5A, ack); tick(2);
    check(ack && gc_cnt == 1 && gc_last == 8'h5A, "R8 gc byte 1", gc_last, 8'h5A);
    write_byte(8'hA5, ack); tick(2);
    check(ack && gc_cnt == 2 && gc_last == 8'hA5, "R8 gc byte 2", gc_last, 8'hA5);
    bus_stop();
    bus_start(); write_byte(8'h01, ack);
    check(!ack, "R8 addr 0 read nack", ack, 0);
    bus_stop();
    gc_en = 1'b0;
    bus_start(); write_byte({OWN, 1'b0}, ack); write_byte(8'h00, ack);
    bus_start(); write_byte({OWN, 1'b1}, ack);
    read_byte(1'b1, d); check(d == expv[0], "R8 regs unchanged 0", d, expv[0]);
    read_byte(1'b0, d); check(d == expv[1], "R8 regs unchanged 1", d, expv[1]);
    bus_stop();

    // R7: NACK then extra clocks see released SDA
    bus_start(); write_byte({OWN, 1'b0}, ack); write_byte(8'h05, ack);
    bus_start(); write_byte({OWN, 1'b1}, ack);
    read_byte(1'b0, d);
    check(d == expv[5], "R7 byte before nack", d, expv[5]);
    for (int i = 0; i < 9; i++) begin
      logic r;
      clock_bit(1'b1, r);
      check(r == 1'b1, "R7 released after nack", r, 1);
    end
    bus_stop();

    // R11: START mid-byte restarts address reception
    bus_start();
    for (int i = 0; i < 4; i++) begin logic r; clock_bit(1'b0, r); end
    bus_start(); write_byte({OWN, 1'b0}, ack);
    check(ack, "R11 addr after aborted byte", ack, 1);
    write_byte(8'h03, ack); write_byte(8'h77, ack); expv[3] = 8'h77;
    bus_start(); write_byte({OWN, 1'b0}, ack); write_byte(8'h03, ack);
    bus_start(); write_byte({OWN, 1'b1}, ack);
    read_byte(1'b0, d);
    check(d == 8'h77, "R11 write after restart", d, 8'h77);
    bus_stop();

    // R9: clock stretch
    ready = 1'b0;
    bus_start(); write_byte({OWN, 1'b0}, ack);
    tick(20);
    check(scl_oe && !scl_line, "R9 stretch after ack", scl_oe, 1);
    ready = 1'b1; tick(2);
    check(!scl_oe, "R9 release on ready", scl_oe, 0);
    write_byte(8'h09, ack);
    check(ack, "R9 transfer continues", ack, 1);
    bus_stop();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule